// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns logical addresses issued by a processor into physical addresses. It treats the upper bits of each logical address as a page number and the lower bits as an offset within the page. A physical address is formed by placing a frame number above the unchanged offset. The frame numbers live in a page table in main memory. Software sets the table's start address and its number of entries through a configuration write port.

An eight-entry fully associative translation cache sits in front of the table and keeps recent page-to-frame pairs. A request that hits the cache completes one cycle after it is accepted and does not touch memory. A request that misses reads exactly one 4-byte table entry over a simple request/acknowledge memory port. It then writes that pair into the cache, replacing entries in round-robin order, and completes. A page number at or beyond the configured table length is refused with a fault flag and produces no memory read. A flush input empties the cache.

Top module: `page_xlate`

## Requirements
- R1: The physical address is the frame number in bits [31:12] joined to the logical address's offset bits [11:0], which pass through unchanged. The page offset width is a parameter limited to 9..13 bits, with a default of 12.
- R2: When the page number (logical address bits [31:12]) is greater than or equal to the configured table length, the result is a done pulse with done_fault_o=1 and done_paddr_o=0. No memory request is raised for that translation.
- R3: On a cache miss that is inside the table length, the cycle after acceptance mem_req_o rises with mem_addr_o = base + 4 × page number. Both are held unchanged until mem_ack_i is high, and req_ready_o stays low during that time.
- R4: The frame number is taken from bits [19:0] of mem_rdata_i in the acknowledge cycle, and bits [31:20] are ignored. done_o pulses in the cycle after the acknowledge, with done_fault_o=0.
- R5: A request that hits the cache gives done_o in the cycle after acceptance and raises no memory request. Hits accepted on consecutive cycles complete on consecutive cycles.
- R6: The cache holds 8 translations. Fills go to the slots in round-robin order, so a ninth distinct page evicts the page that was filled eight fills earlier, while the other seven still hit.
- R7: flush_i invalidates every cache entry, so the next access to any page reads the table. If a flush falls in the same cycle as a fill, the fill is dropped, but that translation still completes.
- R8: A configuration write (cfg_we_i) loads the table base and length at the clock edge. A request accepted in the same cycle is checked and addressed using the previous values.
- R9: After reset, done_o=0, mem_req_o=0, req_ready_o=1, the cache is empty, and base and length are 0, so every request faults until the block is configured. Reset is asserted asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load table base and length |
| cfg_base_i | input | 32 | Page-table start address |
| cfg_len_i | input | 21 | Page-table entry count |
| flush_i | input | 1 | Invalidate all cache entries |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Logical address |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| done_fault_o | output | 1 | Completion refused by the length check |
| done_paddr_o | output | 32 | Physical address, valid with done_o |
| mem_req_o | output | 1 | Table-entry read request |
| mem_addr_o | output | 32 | Table-entry byte address |
| mem_ack_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 32 | Table entry read from memory |

## Verification
A corrupted valid bit or tag shows at the ports in the very next translation of that page. A hit that should have happened raises an unexpected memory request, and a stale hit returns a wrong frame on done_o one cycle after acceptance. A wrong round-robin pointer shows only when the ninth distinct page is filled, because it evicts the wrong page. It is therefore exposed by the access pattern after that fill, several translations later. A fault or walk-state error is visible the cycle after acceptance on done_o, mem_req_o or req_ready_o. The bench's per-cycle reference model compares all of these on every clock.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;

  localparam int unsigned ENTRY_SHIFT = 2;

endpackage

// File: rtl/pxl_tlb.sv
module pxl_tlb #(
  parameter int unsigned NUM_ENT = 8,
  parameter int unsigned PN_W    = 20,
  parameter int unsigned FN_W    = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic [PN_W-1:0] lk_pn_i,
  output logic            lk_hit_o,
  output logic [FN_W-1:0] lk_fn_o,
  input  logic            fill_en_i,
  input  logic [PN_W-1:0] fill_pn_i,
  input  logic [FN_W-1:0] fill_fn_i
);

  localparam int unsigned IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

  logic [NUM_ENT-1:0] val_q, val_d;
  logic [PN_W-1:0]    tag_q [NUM_ENT];
  logic [FN_W-1:0]    fn_q  [NUM_ENT];
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [NUM_ENT-1:0] match;
  logic [NUM_ENT-1:0] wr_sel;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_ent
      assign match[g]  = val_q[g] && (tag_q[g] == lk_pn_i);
      assign wr_sel[g] = fill_en_i && (ptr_q == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (wr_sel[g]) begin
          tag_q[g] <= fill_pn_i;
          fn_q[g]  <= fill_fn_i;
        end
      end
    end
  endgenerate

  always_comb begin
    lk_fn_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match[i]) lk_fn_o = lk_fn_o | fn_q[i];
    end
  end

  assign lk_hit_o = |match;

  always_comb begin
    val_d = val_q;
    ptr_d = ptr_q;
    if (flush_i) begin
      val_d = '0;
    end else if (fill_en_i) begin
      val_d = val_q | wr_sel;
      ptr_d = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      ptr_q <= '0;
    end else begin
      val_q <= val_d;
      ptr_q <= ptr_d;
    end
  end

  AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (val_q == '0)); // R7

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !flush_i) |=>
      (ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1))); // R6

endmodule

// File: rtl/pxl_walk.sv
module pxl_walk
  import pxl_pkg::*;
#(
  parameter int unsigned PN_W  = 20,
  parameter int unsigned FN_W  = 20,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PN_W-1:0]  start_pn_i,
  input  logic [OFF_W-1:0] start_off_i,
  input  logic [PA_W-1:0]  base_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             fin_o,
  output logic [PN_W-1:0]  fin_pn_o,
  output logic [FN_W-1:0]  fin_fn_o,
  output logic [OFF_W-1:0] fin_off_o
);

  walk_state_e      st_q, st_d;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [PN_W-1:0]  pn_q;
  logic [OFF_W-1:0] off_q;
  logic             cap_en;

  assign cap_en = (st_q == WALK_IDLE) && start_i;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    if (cap_en) begin
      st_d   = WALK_BUSY;
      addr_d = base_i + (PA_W'(start_pn_i) << ENTRY_SHIFT);
    end else if ((st_q == WALK_BUSY) && mem_ack_i) begin
      st_d = WALK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WALK_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      pn_q  <= start_pn_i;
      off_q <= start_off_i;
    end
  end

  assign busy_o     = (st_q == WALK_BUSY);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = addr_q;
  assign fin_o      = busy_o && mem_ack_i;
  assign fin_pn_o   = pn_q;
  assign fin_fn_o   = mem_rdata_i[FN_W-1:0];
  assign fin_off_o  = off_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R3

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o); // R3

endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned TLB_ENT   = 8,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned LEN_W     = VA_W - PAGE_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [PA_W-1:0]  cfg_base_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             req_ready_o,
  output logic             done_o,
  output logic             done_fault_o,
  output logic [PA_W-1:0]  done_paddr_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);

  localparam int unsigned PN_W = VA_W - PAGE_BITS;
  localparam int unsigned FN_W = PA_W - PAGE_BITS;

  generate
    if (PAGE_BITS < 9 || PAGE_BITS > 13) begin : g_bad_page
      $error("page offset width must lie in 9..13");
    end
    if (FN_W > PTE_W) begin : g_bad_pte
      $error("frame field wider than table entry");
    end
  endgenerate

  logic rs_a_q, rs_b_q, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a_q <= 1'b0;
      rs_b_q <= 1'b0;
    end else begin
      rs_a_q <= 1'b1;
      rs_b_q <= rs_a_q;
    end
  end
  assign rst_n_s = rs_b_q;

  logic [PA_W-1:0]  base_q, base_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    base_d = base_q;
    len_d  = len_q;
    if (cfg_we_i) begin
      base_d = cfg_base_i;
      len_d  = cfg_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      base_q <= base_d;
      len_q  <= len_d;
    end
  end

  logic [PN_W-1:0]      va_pn;
  logic [PAGE_BITS-1:0] va_off;
  logic                 acc, out_of_range, tlb_hit, miss_start;
  logic [FN_W-1:0]      tlb_fn;
  logic                 walk_busy, walk_fin, fill_en;
  logic [PN_W-1:0]      fin_pn;
  logic [FN_W-1:0]      fin_fn;
  logic [PAGE_BITS-1:0] fin_off;

  assign va_pn        = req_vaddr_i[VA_W-1:PAGE_BITS];
  assign va_off       = req_vaddr_i[PAGE_BITS-1:0];
  assign req_ready_o  = !walk_busy;
  assign acc          = req_valid_i && req_ready_o;
  assign out_of_range = {1'b0, va_pn} >= len_q;
  assign miss_start   = acc && !out_of_range && !tlb_hit;
  assign fill_en      = walk_fin && !flush_i;

  pxl_tlb #(
    .NUM_ENT (TLB_ENT),
    .PN_W    (PN_W),
    .FN_W    (FN_W)
  ) tlb_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .flush_i   (flush_i),
    .lk_pn_i   (va_pn),
    .lk_hit_o  (tlb_hit),
    .lk_fn_o   (tlb_fn),
    .fill_en_i (fill_en),
    .fill_pn_i (fin_pn),
    .fill_fn_i (fin_fn)
  );

  pxl_walk #(
    .PN_W  (PN_W),
    .FN_W  (FN_W),
    .OFF_W (PAGE_BITS),
    .PA_W  (PA_W),
    .PTE_W (PTE_W)
  ) walk_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (miss_start),
    .start_pn_i  (va_pn),
    .start_off_i (va_off),
    .base_i      (base_q),
    .busy_o      (walk_busy),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .fin_o       (walk_fin),
    .fin_pn_o    (fin_pn),
    .fin_fn_o    (fin_fn),
    .fin_off_o   (fin_off)
  );

  logic            done_d, fault_d, rsp_en;
  logic [PA_W-1:0] paddr_d;
  logic            done_q, fault_q;
  logic [PA_W-1:0] paddr_q;

  always_comb begin
    done_d  = 1'b0;
    fault_d = 1'b0;
    paddr_d = '0;
    if (walk_fin) begin
      done_d  = 1'b1;
      paddr_d = {fin_fn, fin_off};
    end else if (acc && out_of_range) begin
      done_d  = 1'b1;
      fault_d = 1'b1;
    end else if (acc && tlb_hit) begin
      done_d  = 1'b1;
      paddr_d = {tlb_fn, va_off};
    end
  end

  assign rsp_en = done_d;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_en) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  assign done_o       = done_q;
  assign done_fault_o = fault_q;
  assign done_paddr_o = paddr_q;

  AST_FAULT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && out_of_range) |=> (done_o && done_fault_o && !mem_req_o)); // R2

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_o && mem_ack_i) |=> (done_o && !done_fault_o)); // R4

  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && !out_of_range && tlb_hit) |=> (done_o && !mem_req_o)); // R5

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && !out_of_range && tlb_hit) |=>
      (done_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0]))); // R1

endmodule

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [20:0] cfg_len = '0;
  logic        drv_flush = 1'b0;
  logic        ack_flush = 1'b0;
  logic        flush;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, done, done_fault, mem_req;
  logic [31:0] done_paddr, mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  assign flush = drv_flush | ack_flush;

  always #5 clk = ~clk;

  page_xlate dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_base_i   (cfg_base),
    .cfg_len_i    (cfg_len),
    .flush_i      (flush),
    .req_valid_i  (req_valid),
    .req_vaddr_i  (req_vaddr),
    .req_ready_o  (req_ready),
    .done_o       (done),
    .done_fault_o (done_fault),
    .done_paddr_o (done_paddr),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_ack_i    (mem_ack),
    .mem_rdata_i  (mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory contents: a table entry is a hash of its address, upper bits junk.
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [19:0] f;
    f = 20'((a >> 2) * 13 + 7);
    return {12'hA5A, f};
  endfunction

  // Memory responder
  int  ack_wait = 0;
  bit  flush_on_ack = 0;
  always @(negedge clk) begin
    mem_ack   = 1'b0;
    ack_flush = 1'b0;
    if (rst_n && mem_req) begin
      if (ack_wait == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = pte_of(mem_addr);
        ack_flush = flush_on_ack;
        ack_wait  = int'($urandom_range(0, 3));
      end else begin
        ack_wait--;
      end
    end
  end

  // Behavioural reference model, advanced on each rising edge
  int          rel_cnt = 0;
  int          m_tag [8];
  logic [19:0] m_frm [8];
  bit          m_val [8];
  int          m_ptr;
  bit          m_fetch;
  logic [31:0] m_addr;
  int          m_pn;
  logic [11:0] m_off;
  logic [31:0] m_base;
  int          m_len;
  bit          e_done, e_fault;
  logic [31:0] e_paddr;

  always @(posedge clk) begin
    if (!rst_n || rel_cnt < 2) begin
      foreach (m_val[i]) m_val[i] = 0;
      m_ptr = 0; m_fetch = 0; m_addr = '0; m_base = '0; m_len = 0;
      e_done = 0; e_fault = 0; e_paddr = '0;
      if (rst_n) rel_cnt++; else rel_cnt = 0;
    end else begin
      bit nd, nf, hit, was_fetch;
      logic [31:0] np;
      int pn;
      nd = 0; nf = 0; np = '0;
      was_fetch = m_fetch;
      if (!was_fetch && req_valid) begin
        pn = int'(req_vaddr[31:12]);
        if (pn >= m_len) begin
          nd = 1; nf = 1;
        end else begin
          hit = 0;
          foreach (m_val[i]) if (m_val[i] && m_tag[i] == pn) begin
            hit = 1; np = {m_frm[i], req_vaddr[11:0]};
          end
          if (hit) nd = 1;
          else begin
            m_fetch = 1; m_pn = pn; m_off = req_vaddr[11:0];
            m_addr = m_base + 32'(pn) * 4;
          end
        end
      end else if (was_fetch && mem_ack) begin
        nd = 1; np = {mem_rdata[19:0], m_off};
        m_fetch = 0;
        if (!flush) begin
          m_val[m_ptr] = 1; m_tag[m_ptr] = m_pn; m_frm[m_ptr] = mem_rdata[19:0];
          m_ptr = (m_ptr + 1) % 8;
        end
      end
      if (flush) foreach (m_val[i]) m_val[i] = 0;
      if (cfg_we) begin m_base = cfg_base; m_len = int'(cfg_len); end
      e_done = nd;
      if (nd) begin e_fault = nf; e_paddr = np; end
    end
  end

  // Compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ok;
      ok = (done == e_done) && (req_ready == !m_fetch) && (mem_req == m_fetch)
           && (!m_fetch || mem_addr == m_addr)
           && (!e_done || (done_fault == e_fault && done_paddr == e_paddr));
      checks++;
      if (!ok) begin
        errors++;
        if (mem_req != m_fetch || (m_fetch && mem_addr != m_addr))
          $display("FAIL R3 model mem: actual=%h/%h expected=%h/%h",
                   mem_req, mem_addr, m_fetch, m_addr);
        else if (done != e_done)
          $display("FAIL R5 model done: actual=%h expected=%h", done, e_done);
        else if (done_fault != e_fault)
          $display("FAIL R2 model fault: actual=%h expected=%h", done_fault, e_fault);
        else if (req_ready == m_fetch)
          $display("FAIL R3 model ready: actual=%h expected=%h", req_ready, !m_fetch);
        else
          $display("FAIL R1 model paddr: actual=%h expected=%h", done_paddr, e_paddr);
      end
    end
  end

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                       output bit flt, output bit walked);
    walked = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      if (mem_req) walked = 1;
      @(negedge clk);
    end
    pa = done_paddr; flt = done_fault;
  endtask

  task automatic set_cfg(input logic [31:0] b, input int len);
    cfg_we = 1'b1; cfg_base = b; cfg_len = 21'(len);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_flush();
    drv_flush = 1'b1;
    @(negedge clk);
    drv_flush = 1'b0;
  endtask

  localparam logic [31:0] BASE = 32'h0001_0000;

  function automatic logic [31:0] exp_pa(input int pn, input logic [11:0] off);
    logic [31:0] e;
    e = pte_of(BASE + 32'(pn) * 4);
    return {e[19:0], off};
  endfunction

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] pa;
    bit flt, w;
    int nwalk;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk(done == 0 && mem_req == 0 && req_ready == 1, "R9", "reset outputs",
        {29'b0, done, mem_req, req_ready}, 32'h1);
    xlate(32'h0000_0ABC, pa, flt, w);
    chk(flt == 1 && !w, "R9", "unconfigured faults", {31'b0, flt}, 32'h1);

    set_cfg(BASE, 16);

    // R3/R4/R1 miss path
    xlate({20'd3, 12'h123}, pa, flt, w);
    chk(w, "R3", "miss walks", {31'b0, w}, 32'h1);
    chk(!flt && pa == exp_pa(3, 12'h123), "R4", "frame from entry", pa, exp_pa(3, 12'h123));
    // R5 hit path
    xlate({20'd3, 12'hFFF}, pa, flt, w);
    chk(!w, "R5", "hit no walk", {31'b0, w}, 32'h0);
    chk(pa == exp_pa(3, 12'hFFF), "R1", "offset kept", pa, exp_pa(3, 12'hFFF));

    // R2 length bound
    xlate({20'd16, 12'h001}, pa, flt, w);
    chk(flt && !w && pa == 0, "R2", "at limit faults", pa, 32'h0);
    xlate({20'd15, 12'h002}, pa, flt, w);
    chk(!flt && pa == exp_pa(15, 12'h002), "R2", "last entry ok", pa, exp_pa(15, 12'h002));

    // R6 round-robin eviction
    pulse_flush();
    nwalk = 0;
    for (int p = 0; p < 9; p++) begin
      xlate({20'(p), 12'h010}, pa, flt, w);
      nwalk += int'(w);
    end
    chk(nwalk == 9, "R6", "nine fills", 32'(nwalk), 32'd9);
    xlate({20'd1, 12'h020}, pa, flt, w);
    chk(!w, "R6", "second page kept", {31'b0, w}, 32'h0);
    xlate({20'd0, 12'h020}, pa, flt, w);
    chk(w, "R6", "oldest evicted", {31'b0, w}, 32'h1);

    // R5 back-to-back hits (pages 2 and 3 still cached)
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = {20'd2, 12'h0AA};
    @(negedge clk);
    req_vaddr = {20'd3, 12'h0BB};
    chk(done && done_paddr == exp_pa(2, 12'h0AA), "R5", "first hit", done_paddr, exp_pa(2, 12'h0AA));
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && done_paddr == exp_pa(3, 12'h0BB), "R5", "second hit", done_paddr, exp_pa(3, 12'h0BB));

    // R7 flush
    pulse_flush();
    xlate({20'd2, 12'h000}, pa, flt, w);
    chk(w, "R7", "flushed page walks", {31'b0, w}, 32'h1);
    // R7 flush coinciding with fill drops the fill
    pulse_flush();
    flush_on_ack = 1;
    xlate({20'd9, 12'h321}, pa, flt, w);
    flush_on_ack = 0;
    chk(w && pa == exp_pa(9, 12'h321), "R7", "result despite drop", pa, exp_pa(9, 12'h321));
    xlate({20'd9, 12'h321}, pa, flt, w);
    chk(w, "R7", "dropped fill walks again", {31'b0, w}, 32'h1);

    // R8 config write same cycle as request uses old length
    xlate({20'd5, 12'h000}, pa, flt, w);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = {20'd5, 12'h055};
    cfg_we = 1'b1; cfg_base = BASE; cfg_len = 21'd2;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk(done && !done_fault, "R8", "old length used", {31'b0, done_fault}, 32'h0);
    xlate({20'd5, 12'h055}, pa, flt, w);
    chk(flt, "R8", "new length applied", {31'b0, flt}, 32'h1);
    set_cfg(BASE, 16);

    // Random traffic checked by the model every clock (R1..R5)
    for (int c = 0; c < 3000; c++) begin
      req_valid = ($urandom_range(0, 1) == 1);
      req_vaddr = {20'($urandom_range(0, 19)), 12'($urandom)};
      drv_flush = ($urandom_range(0, 49) == 0);
      @(negedge clk);
    end
    req_valid = 1'b0; drv_flush = 1'b0;
    repeat (10) @(negedge clk);
    summary();
  end

endmodule